// File: doc/BRIEF.md
# Flash Sector Load and Program Controller

This block is a clock-synchronous model of the write path inside a word-wide flash memory. A host drives active-low chip-enable, output-enable and write-enable together with an address and a data word. Each qualified write strobe places one word into a latch buffer that holds one sector. The first accepted word opens a load window and fixes which sector the window belongs to. Further words for that sector may arrive in any order.

When no new strobe arrives for a set number of cycles, the window closes by itself. The controller then erases the whole sector in the storage array to all ones and writes back only the words that were loaded. Any word that was not loaded therefore reads as all ones. The program cycle has a fixed length in clock cycles.

When the controller is idle, a bus read (chip-enable and output-enable low, write-enable high) returns the stored word one cycle later. While a window is open or a program cycle is running, reads return nothing. The timeout, the program length and the strobe filter length are parameters, so a short configuration can be exercised quickly.

Top module: `flash_sector_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `sector_err` and `rd_valid` are 0.
- R2: In idle, a cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1 returns the array word at `addr` on `rdata` with `rd_valid`=1 in the next cycle.
- R3: A write strobe is the condition `ce_n`=0, `we_n`=0, `oe_n`=1. A word is loaded only when the strobe lasts at least `FILT_CYC` consecutive cycles. A shorter strobe loads nothing and does not open a window.
- R4: The load address is taken in the first cycle of the strobe, which is the cycle in which the later of the two enables has fallen. The load data is taken in the cycle in which the strobe ends.
- R5: Address bits [ADDR_W-1:7] select the sector and bits [6:0] select the word within a 128-word sector. Words may be loaded in any order.
- R6: `busy` rises in the cycle after the first load is accepted. The window closes after `LOAD_TMO` consecutive cycles with no accepted load and no strobe in progress. Programming then takes max(`PROG_CYC`, 257) cycles, after which `busy` falls.
- R7: Programming first writes all ones over the whole sector, then writes every loaded word. Unloaded words read 16'hFFFF and other sectors keep their contents.
- R8: Inside an open window, a load whose sector differs from the window's sector is ignored and sets `sector_err`. `sector_err` clears when the next window opens.
- R9: While `busy` is 1, a bus read gives `rd_valid`=0 and `rdata`=0 in the following cycle.
- R10: A strobe with `oe_n`=0 loads nothing and opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Load window open or program cycle running |
| sector_err | output | 1 | Load to a foreign sector seen in this window |

## Verification
The bench targets the following corner cases:
- Sectors loaded in reverse order and with only even words. A design that ignored the loaded-word mask, or skipped the erase, would leave stale data where all ones are expected.
- A strobe one cycle shorter than the filter length, and a strobe held with output-enable low. Either one must leave `busy` low; a design that did not filter or inhibit would open a window.
- A strobe whose address changes after the enables overlap and whose data changes at release. A design that took the address or data in the wrong cycle would store the word at the wrong place or with the wrong value.
- The exact length of `busy` after the last load, and a stray load to a sector that was programmed earlier. The second must leave that sector untouched and raise the error flag.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_ERASE  = 3'd2,
    ST_PROG   = 3'd3,
    ST_SETTLE = 3'd4
  } fl_state_e;
endpackage

// File: rtl/flash_strobe_filter.sv
module flash_strobe_filter #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int FILT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ld_valid,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              in_strobe
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);

  logic          act;
  logic [CW-1:0] cnt_q;

  // Strobe: chip selected, write enable low, outputs not enabled
  assign act       = !ce_n && !we_n && oe_n;
  assign in_strobe = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ld_valid <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
    end else begin
      ld_valid <= 1'b0;
      if (act) begin
        // first overlapping cycle: both enables low, capture address
        if (cnt_q == '0) ld_addr <= addr;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else begin
        // strobe released: data comes from the release cycle
        if (cnt_q == CNT_MAX) begin
          ld_valid <= 1'b1;
          ld_data  <= wdata;
        end
        cnt_q <= '0;
      end
    end
  end

  // R3: one release can yield only a single load pulse
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid);

  // R3: a load pulse always follows a strobe that was in progress
  assert_load_after_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(in_strobe));
endmodule

// File: rtl/flash_load_buffer.sv
module flash_load_buffer #(
  parameter int DATA_W    = 16,
  parameter int WORD_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 wr,
  input  logic [WORD_BITS-1:0] widx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [WORD_BITS-1:0] ridx,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rloaded
);
  localparam int SECT_N = 1 << WORD_BITS;

  logic [DATA_W-1:0] words_q [SECT_N];
  logic [SECT_N-1:0] mask_q;

  // word storage: no reset, one write port (distributed RAM style)
  always_ff @(posedge clk) begin
    if (wr) words_q[widx] <= wdata;
  end

  // loaded-word mask, one flag per word of the sector
  genvar gi;
  generate
    for (gi = 0; gi < SECT_N; gi++) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q[gi] <= 1'b0;
        end else if (wr && (widx == WORD_BITS'(gi))) begin
          mask_q[gi] <= 1'b1;
        end else if (clr) begin
          mask_q[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  assign rdata   = words_q[ridx];
  assign rloaded = mask_q[ridx];

  // R5: any word written is marked loaded afterwards
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> mask_q[$past(widx)]);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read; output forced to zero when not reading
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    else    rdata <= '0;
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WORD_BITS = 7,
  parameter int LOAD_TMO  = 1000,
  parameter int PROG_CYC  = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_valid,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic                 in_strobe,
  input  logic                 buf_loaded,
  output logic                 buf_clr,
  output logic                 buf_wr,
  output logic [WORD_BITS-1:0] buf_widx,
  output logic [WORD_BITS-1:0] buf_ridx,
  output logic                 mem_we,
  output logic                 mem_erase,
  output logic [ADDR_W-1:0]    mem_waddr,
  output logic                 busy,
  output logic                 sector_err
);
  localparam int SECT_W     = ADDR_W - WORD_BITS;
  localparam int SECT_N     = 1 << WORD_BITS;
  localparam int MIN_PROG   = 2 * SECT_N + 1;
  localparam int PROG_TOTAL = (PROG_CYC > MIN_PROG) ? PROG_CYC : MIN_PROG;
  localparam int GAP_W      = $clog2(LOAD_TMO + 1);
  localparam int CYC_W      = $clog2(PROG_TOTAL + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_TMO - 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PROG_TOTAL - 1);

  fl_state_e            state_q;
  logic [SECT_W-1:0]    win_sect_q;
  logic [GAP_W-1:0]     gap_q;
  logic [WORD_BITS-1:0] idx_q;
  logic [CYC_W-1:0]     cyc_q;
  logic                 err_q;
  logic                 same_sect;

  assign same_sect = (ld_addr[ADDR_W-1:WORD_BITS] == win_sect_q);

  assign buf_clr   = (state_q == ST_IDLE) && ld_valid;
  assign buf_wr    = ld_valid &&
                     ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && same_sect));
  assign buf_widx  = ld_addr[WORD_BITS-1:0];
  assign buf_ridx  = idx_q;
  assign mem_erase = (state_q == ST_ERASE);
  assign mem_we    = mem_erase || ((state_q == ST_PROG) && buf_loaded);
  assign mem_waddr = {win_sect_q, idx_q};
  assign busy      = (state_q != ST_IDLE);
  assign sector_err = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      win_sect_q <= '0;
      gap_q      <= '0;
      idx_q      <= '0;
      cyc_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ld_valid) begin
            state_q    <= ST_LOAD;
            win_sect_q <= ld_addr[ADDR_W-1:WORD_BITS];
            err_q      <= 1'b0;
            gap_q      <= '0;
          end
        end
        ST_LOAD: begin
          if (ld_valid) begin
            if (same_sect) gap_q <= '0;
            else           err_q <= 1'b1;
          end else if (!in_strobe) begin
            if (gap_q == GAP_LAST) begin
              state_q <= ST_ERASE;
              idx_q   <= '0;
              cyc_q   <= '0;
            end else begin
              gap_q <= gap_q + 1'b1;
            end
          end
        end
        ST_ERASE: begin
          cyc_q <= cyc_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) state_q <= ST_PROG;
        end
        ST_PROG: begin
          cyc_q <= cyc_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          if (idx_q == '1) state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cyc_q == CYC_LAST) state_q <= ST_IDLE;
          else                   cyc_q   <= cyc_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: window sector never moves while loading
  assert_window_sector_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD) |=> (state_q != ST_LOAD) || $stable(win_sect_q));

  // R8: the error flag only rises on an accepted load pulse
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(ld_valid));

  // R6: busy only ends after the settle phase
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(state_q) == ST_SETTLE));

  // R7: erase pass is immediately followed by the program pass
  assert_erase_then_prog_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) |=> (state_q == ST_ERASE) || (state_q == ST_PROG));
endmodule

// File: rtl/flash_sector_ctrl.sv
module flash_sector_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int WORD_BITS = 7,
  parameter int FILT_CYC  = 2,
  parameter int LOAD_TMO  = 1000,
  parameter int PROG_CYC  = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              busy,
  output logic              sector_err
);
  logic                 ld_valid;
  logic [ADDR_W-1:0]    ld_addr;
  logic [DATA_W-1:0]    ld_data;
  logic                 in_strobe;
  logic                 buf_clr, buf_wr, buf_loaded;
  logic [WORD_BITS-1:0] buf_widx, buf_ridx;
  logic [DATA_W-1:0]    buf_rdata;
  logic                 mem_we, mem_erase;
  logic [ADDR_W-1:0]    mem_waddr;
  logic [DATA_W-1:0]    mem_wdata;
  logic                 rd_en;

  flash_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC)
  ) u_filt (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .in_strobe(in_strobe)
  );

  flash_load_buffer #(
    .DATA_W(DATA_W), .WORD_BITS(WORD_BITS)
  ) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr(buf_wr), .widx(buf_widx),
    .wdata(ld_data), .ridx(buf_ridx), .rdata(buf_rdata), .rloaded(buf_loaded)
  );

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .WORD_BITS(WORD_BITS),
    .LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .in_strobe(in_strobe), .buf_loaded(buf_loaded), .buf_clr(buf_clr),
    .buf_wr(buf_wr), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
    .mem_we(mem_we), .mem_erase(mem_erase), .mem_waddr(mem_waddr),
    .busy(busy), .sector_err(sector_err)
  );

  assign mem_wdata = mem_erase ? {DATA_W{1'b1}} : buf_rdata;
  assign rd_en     = !ce_n && !oe_n && we_n && !busy && !ld_valid;

  flash_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_en), .raddr(addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  // R9: no read result can follow a busy cycle
  assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rd_valid);

  // R7: the array is only written while the block reports busy
  assert_write_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

// File: tb/flash_sector_ctrl_test.sv
module flash_sector_ctrl_test;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;
  localparam int WB     = 7;
  localparam int FILT   = 3;
  localparam int TMO    = 20;
  localparam int PROG   = 300;

  logic              clk = 1'b0;
  logic              rst;
  logic              ce_n, oe_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid, busy, sector_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_sector_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BITS(WB),
    .FILT_CYC(FILT), .LOAD_TMO(TMO), .PROG_CYC(PROG)
  ) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .busy(busy), .sector_err(sector_err)
  );

  function automatic logic [15:0] fa(input int i);
    return 16'(i * 40503 + 4660);
  endfunction
  function automatic logic [15:0] fb(input int i);
    return 16'(i * 7919 + 999);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic load_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input int len, input int gap);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    repeat (gap) @(negedge clk);
  endtask

  task automatic read_word(input logic [ADDR_W-1:0] a, output logic [15:0] d,
                           output logic v);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    d = rdata; v = rd_valid;
    go_idle();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        v;
    int          n;
    logic [15:0] e;

    rst = 1'b1; go_idle(); addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 sector_err", 32'(sector_err), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);

    // Window A: sector 1, every word, reverse order (R5, R6, R9)
    load_word(9'(128 + 127), fa(127), FILT, 1);
    chk("R6 busy after first load", 32'(busy), 32'd1);
    read_word(9'(128), d, v);
    chk("R9 rd_valid while busy", 32'(v), 32'd0);
    chk("R9 rdata while busy", 32'(d), 32'd0);
    for (int i = 126; i >= 0; i--) load_word(9'(128 + i), fa(i), FILT, 1);
    wait_idle(n);
    chk("R6 busy length", 32'(n), 32'(TMO + PROG));
    for (int i = 0; i < 128; i++) begin
      read_word(9'(128 + i), d, v);
      chk("R2 rd_valid", 32'(v), 32'd1);
      chk("R5 sector 1 data", 32'(d), 32'(fa(i)));
    end

    // Window B: sector 2; short strobe (R3), OE inhibit (R10), capture (R4)
    load_word(9'(256 + 1), 16'h0000, FILT - 1, 2);
    chk("R3 short strobe opens no window", 32'(busy), 32'd0);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 9'(256 + 3); wdata = 16'h0BAD;
    repeat (5) @(negedge clk);
    go_idle();
    repeat (2) @(negedge clk);
    chk("R10 oe low strobe opens no window", 32'(busy), 32'd0);
    for (int i = 0; i < 128; i += 2)
      if (i != 10) load_word(9'(256 + i), fb(i), FILT, 1);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 9'(256 + 11); wdata = 16'h1111;
    @(negedge clk);
    we_n = 1'b0; addr = 9'(256 + 10); wdata = 16'h2222;
    @(negedge clk);
    addr = 9'(256 + 13);
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; wdata = 16'hC3C3;
    repeat (2) @(negedge clk);
    wait_idle(n);
    for (int i = 0; i < 128; i++) begin
      if (i == 10)         e = 16'hC3C3;
      else if (i % 2 == 0) e = fb(i);
      else                 e = 16'hFFFF;
      read_word(9'(256 + i), d, v);
      chk((i == 10) ? "R4 capture word" : "R7 sector 2 data", 32'(d), 32'(e));
    end

    // Window C: sector 3 with a stray load to sector 1 (R8)
    for (int i = 0; i < 4; i++) load_word(9'(384 + i), 16'(16'hA000 + i), FILT, 1);
    load_word(9'(128 + 5), 16'hDEAD, FILT, 1);
    chk("R8 sector_err set", 32'(sector_err), 32'd1);
    wait_idle(n);
    for (int i = 0; i < 5; i++) begin
      read_word(9'(384 + i), d, v);
      chk("R7 sector 3 data", 32'(d), (i < 4) ? 32'(16'hA000 + i) : 32'h0000FFFF);
    end
    read_word(9'(128 + 5), d, v);
    chk("R8 stray load ignored", 32'(d), 32'(fa(5)));

    // Window D: reprogram sector 1 with one word (R7, R8 clear)
    load_word(9'(128), 16'h5A5A, FILT, 1);
    chk("R8 sector_err cleared", 32'(sector_err), 32'd0);
    wait_idle(n);
    read_word(9'(128), d, v);
    chk("R7 reloaded word", 32'(d), 32'h5A5A);
    read_word(9'(128 + 5), d, v);
    chk("R7 erased word 5", 32'(d), 32'hFFFF);
    read_word(9'(128 + 127), d, v);
    chk("R7 erased word 127", 32'(d), 32'hFFFF);
    chk("R1 idle busy at end", 32'(busy), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule